// File: doc/BRIEF.md
# I2C Configuration Register Target with Address Pointer

This block is an I2C target that lets a bus controller read and write a small bank of 8-bit configuration registers. Access goes through a pointer byte that the controller loads at the start of every write. The pointer keeps its value from one transaction to the next, so a later read starts where the last write left it. Bit 7 of the pointer is a step flag. When the flag is set, consecutive data bytes walk through successive registers. When it is clear, every data byte goes to the same register.

The block oversamples SCL and SDA with the system clock. It detects START, repeated START and STOP, and it drives the open-drain SDA line through a single enable. The register contents are presented in parallel to the rest of the chip. One external strap input supplies the low bit of the device address, so two copies can share a bus.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth SCL pulse) an address byte whose upper six bits are 001000 and whose bit 1 equals `addr_sel_i`. Bit 0 of that byte is the direction flag, and 1 means read.
- R2: An address byte that does not match gets no acknowledge. The target then leaves SDA released and changes no register and no pointer state until the next START.
- R3: In a write, the first byte after the address loads the pointer and is not stored in any register. Bit 7 of that byte is the step flag and the low bits are the register index.
- R4: Each later write byte is stored in the register at the pointer index and acknowledged. With the step flag set, the index advances by one after each byte and wraps from the last register to register 0. With the flag clear, the index stays put.
- R5: After acknowledging a read address, the target sends the register at the pointer index MSB first, starting with the next SCL low phase.
- R6: During a read, each byte the controller acknowledges is followed by another byte. With the step flag set, that byte comes from the next register (wrapping). With the flag clear, the same register is sent again.
- R7: The pointer is kept across transactions. After reset it holds index 1 with the step flag clear, and register i resets to 0x80 + i.
- R8: When the controller does not acknowledge a read byte, the target releases SDA, sends nothing more and leaves the pointer unchanged until STOP or repeated START.
- R9: STOP returns the target to idle. A repeated START begins a new address phase at once.
- R10: The target changes its SDA drive only while SCL is low.
- R11: During and right after reset, SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL by a wide margin |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_sel_i | input | 1 | Strap that sets address bit 1 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_regs_o | output | NUM_REGS*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with its defaults: eight registers and the 001000 prefix. With eight registers the wrap from register 7 to register 0 is reachable in a write of two bytes. The reset values 0x80 + i are small and distinct, so a read shows directly which register was sent and whether the pointer moved. The strap input is driven to both levels, which reaches both the matching and the non-matching address paths.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    // upper six bits of the device address
    localparam logic [5:0] DEV_PREFIX = 6'b001000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MAP_RX,
        ST_WR_RX,
        ST_ACK,
        ST_RD_TX,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_WAIT
    } tgt_state_e;

    // layout of the pointer byte as it arrives on the bus
    typedef struct packed {
        logic       step;
        logic [6:0] idx;
    } ptr_byte_t;

    function automatic logic [7:0] reg_reset_val(input int idx);
        return 8'h80 + 8'(idx);
    endfunction

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic scl_steady_hi,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    assign sda_lvl       = sda_sync[1];
    assign scl_rise      = scl_sync[1] & ~scl_prev;
    assign scl_fall      = ~scl_sync[1] & scl_prev;
    assign scl_steady_hi = scl_sync[1] & scl_prev;
    assign start_det     = scl_steady_hi & sda_prev & ~sda_sync[1];
    assign stop_det      = scl_steady_hi & ~sda_prev & sda_sync[1];

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [AW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    logic [7:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= reg_reset_val(g);
            else if (wr_en && wr_idx == AW'(g))
                bank[g] <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = bank[g];
    end

    assign rd_data = bank[rd_idx];

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int       NUM_REGS  = 8,
    parameter int       PTR_RESET = 1,
    localparam int      AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_sel_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_regs_o
);
    logic scl_rise, scl_fall, scl_steady_hi, sda_lvl, start_det, stop_det;

    i2c_bus_sense u_sense (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .scl_steady_hi (scl_steady_hi),
        .sda_lvl       (sda_lvl),
        .start_det     (start_det),
        .stop_det      (stop_det)
    );

    tgt_state_e st, ack_nxt;
    logic [3:0]    bit_cnt;
    logic [7:0]    rx_sh, tx_sh;
    logic          ack_drv, is_read;
    logic          ptr_step;
    logic [AW-1:0] ptr_idx;
    logic [7:0]    rd_data;
    logic [7:0]    rx_byte;
    ptr_byte_t     ptr_in;
    logic          byte_done, wr_en;

    assign rx_byte   = {rx_sh[6:0], sda_lvl};
    assign ptr_in    = ptr_byte_t'(rx_byte);
    assign byte_done = scl_rise && bit_cnt == 4'd7;
    assign wr_en     = (st == ST_WR_RX) && byte_done && !start_det && !stop_det;

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (ptr_idx),
        .wr_data   (rx_byte),
        .rd_idx    (ptr_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ack_nxt  <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ack_drv  <= 1'b0;
            is_read  <= 1'b0;
            sda_oe_o <= 1'b0;
            ptr_step <= 1'b0;
            ptr_idx  <= AW'(PTR_RESET);
        end else if (start_det) begin
            st       <= ST_ADDR;
            bit_cnt  <= '0;
            ack_drv  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            sda_oe_o <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_MAP_RX, ST_WR_RX: begin
                    if (scl_rise) begin
                        rx_sh   <= rx_byte;
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        ack_drv <= 1'b0;
                        if (st == ST_ADDR) begin
                            if (rx_byte[7:1] == {DEV_PREFIX, addr_sel_i}) begin
                                is_read <= rx_byte[0];
                                ack_nxt <= rx_byte[0] ? ST_RD_TX : ST_MAP_RX;
                                st      <= ST_ACK;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end else if (st == ST_MAP_RX) begin
                            ptr_step <= ptr_in.step;
                            ptr_idx  <= ptr_in.idx[AW-1:0];
                            ack_nxt  <= ST_WR_RX;
                            st       <= ST_ACK;
                        end else begin
                            if (ptr_step) ptr_idx <= ptr_idx + AW'(1);
                            ack_nxt <= ST_WR_RX;
                            st      <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_drv) begin
                            sda_oe_o <= 1'b1;
                            ack_drv  <= 1'b1;
                        end else begin
                            ack_drv <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ack_nxt;
                            if (ack_nxt == ST_RD_TX) begin
                                tx_sh    <= rd_data;
                                sda_oe_o <= ~rd_data[7];
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                end
                ST_RD_TX: begin
                    if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe_o <= 1'b0;
                            st       <= ST_RD_ACK;
                        end else begin
                            tx_sh    <= {tx_sh[6:0], 1'b0};
                            sda_oe_o <= ~tx_sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        if (!sda_lvl) begin
                            if (ptr_step) ptr_idx <= ptr_idx + AW'(1);
                            st <= ST_RD_NEXT;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_RD_NEXT: begin
                    if (scl_fall) begin
                        tx_sh    <= rd_data;
                        sda_oe_o <= ~rd_data[7];
                        bit_cnt  <= '0;
                        st       <= ST_RD_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        scl_steady_hi |-> $stable(sda_oe_o));

    // R2
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (!sda_oe_o && $stable(ptr_idx)));

    // R5
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) != ST_RD_TX && st == ST_RD_TX) |-> (sda_oe_o == !rd_data[7]));

    // R11
    reset_release_chk: assert property (@(posedge clk)
        rst |=> !sda_oe_o);

    // R8
    nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_ACK && scl_rise && sda_lvl && !start_det && !stop_det)
            |=> (st == ST_WAIT && $stable(ptr_idx)));

endmodule

// File: tb/tb_i2c_cfg_target.sv
`timescale 1ns/1ps
module tb_i2c_cfg_target;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sel = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_bus = ~(m_low | sda_oe);

    int total = 0;
    int bad = 0;
    int r10_viol = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    i2c_cfg_target dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .addr_sel_i (sel),
        .sda_oe_o   (sda_oe),
        .cfg_regs_o (regs)
    );

    // R10 monitor: drive must not move while SCL stays high
    always @(negedge clk) begin
        if (!rst && scl && prev_scl && sda_oe !== prev_oe) r10_viol++;
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    function automatic logic [7:0] rg(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        if (scl) begin
            m_low = 1'b1; wq(); scl = 1'b0; wq();
        end else begin
            m_low = 1'b0; wq(); scl = 1'b1; wq();
            m_low = 1'b1; wq(); scl = 1'b0; wq();
        end
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        m_low = 1'b0; wq(); scl = 1'b1; wq();
        ack = ~sda_bus;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic read_byte(input logic do_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; wq(); scl = 1'b1; wq();
            b[i] = sda_bus;
            wq(); scl = 1'b0; wq();
        end
        m_low = do_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] addr_byte(input logic s, input logic rd);
        return {6'b001000, s, rd};
    endfunction

    task automatic t_reset();
        chk("R11 oe after reset", {7'd0, sda_oe}, 8'h00);
        for (int i = 0; i < NREG; i++) chk("R7 reg reset", rg(i), 8'h80 + 8'(i));
    endtask

    task automatic t_read_default();
        logic a; logic [7:0] d;
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        chk("R1 read addr ack", {7'd0, a}, 8'h01);
        read_byte(1'b0, d);
        chk("R5 R7 default pointer read", d, 8'h81);
        bus_stop();
    endtask

    task automatic t_write_step();
        logic a; logic [7:0] d;
        bus_start(); send_byte(addr_byte(1'b1, 1'b0), a);
        chk("R1 write addr ack", {7'd0, a}, 8'h01);
        send_byte(8'h83, a);
        chk("R3 pointer byte ack", {7'd0, a}, 8'h01);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        chk("R4 data ack", {7'd0, a}, 8'h01);
        bus_stop();
        chk("R4 reg3", rg(3), 8'h11);
        chk("R4 reg4", rg(4), 8'h22);
        chk("R4 reg5", rg(5), 8'h33);
        chk("R3 reg1 untouched", rg(1), 8'h81);
        chk("R3 reg2 untouched", rg(2), 8'h82);
        // pointer now 6 with step flag: read 6, 7 then NACK
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        read_byte(1'b1, d); chk("R6 R7 persistent read", d, 8'h86);
        read_byte(1'b0, d); chk("R6 stepped read", d, 8'h87);
        bus_stop();
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        read_byte(1'b0, d); chk("R8 no advance after NACK", d, 8'h87);
        bus_stop();
    endtask

    task automatic t_fixed_ptr();
        logic a; logic [7:0] d;
        bus_start(); send_byte(addr_byte(1'b1, 1'b0), a);
        send_byte(8'h02, a); send_byte(8'h55, a); send_byte(8'h66, a);
        bus_stop();
        chk("R4 fixed pointer reg2", rg(2), 8'h66);
        chk("R4 fixed pointer reg3 kept", rg(3), 8'h11);
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        read_byte(1'b1, d); chk("R6 fixed read first", d, 8'h66);
        read_byte(1'b0, d); chk("R6 fixed read repeat", d, 8'h66);
        // repeated START: new pointer, then read without STOP in between
        bus_start(); send_byte(addr_byte(1'b1, 1'b0), a);
        chk("R9 repeated start addr ack", {7'd0, a}, 8'h01);
        send_byte(8'h85, a);
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        read_byte(1'b0, d); chk("R9 read after repeated start", d, 8'h33);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a; logic [7:0] d;
        bus_start(); send_byte(addr_byte(1'b0, 1'b0), a);
        chk("R2 no ack on wrong address", {7'd0, a}, 8'h00);
        send_byte(8'h04, a); send_byte(8'h99, a);
        chk("R2 later bytes ignored", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R2 reg4 unchanged", rg(4), 8'h22);
        // pointer should still be 5 with step flag
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        read_byte(1'b0, d); chk("R2 pointer unchanged", d, 8'h33);
        bus_stop();
    endtask

    task automatic t_strap_and_wrap();
        logic a; logic [7:0] d;
        sel = 1'b0;
        bus_start(); send_byte(addr_byte(1'b1, 1'b1), a);
        chk("R1 strap low rejects bit1=1", {7'd0, a}, 8'h00);
        bus_stop();
        bus_start(); send_byte(addr_byte(1'b0, 1'b0), a);
        chk("R1 strap low accepts bit1=0", {7'd0, a}, 8'h01);
        send_byte(8'h87, a); send_byte(8'hA1, a); send_byte(8'hA2, a);
        bus_stop();
        chk("R4 wrap reg7", rg(7), 8'hA1);
        chk("R4 wrap reg0", rg(0), 8'hA2);
        bus_start(); send_byte(addr_byte(1'b0, 1'b1), a);
        read_byte(1'b1, d); chk("R6 read after wrap", d, 8'h81);
        read_byte(1'b0, d); chk("R6 read next", d, 8'h66);
        bus_stop();
        sel = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 chk("R11 oe during reset", {7'd0, sda_oe}, 8'h00);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_read_default();
        t_write_step();
        t_fixed_ptr();
        t_mismatch();
        t_strap_and_wrap();
        total++;
        if (r10_viol != 0) begin
            bad++;
            $display("FAIL R10 actual=%0d expected=0 drive changes with SCL high", r10_viol);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule